// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one decoded operand specifier into the memory address of that operand. A specifier names one of four base modes: register indirect, post-increment, pre-decrement and base plus displacement. It also carries a flag that makes the computed location hold a pointer, an optional index register, the operand size and the displacement width. The block reads the base and index registers through two read ports of an external 16 x 32 register file. It writes the base register back when the mode calls for it. When the pointer flag is set, it issues one read on a simple request/valid memory port.

A request is taken with a valid/ready handshake, one at a time. The result appears on `ea_o` together with a one-cycle `done_o` strobe. Register 15 holds the program counter. The decoder supplies its value on `pc_i`, already advanced past the specifier's extension bytes. That value replaces the register file whenever register 15 is named. Fetching the operand and writing results are left to other blocks.

Top module: `opnd_ea_gen`

## Requirements
- R1: `req_ready_o` is high only when no request is in flight. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from the cycle after acceptance until `done_o` is asserted.
- R2: For a request with `defer_i` = 0, `done_o` is high for exactly one cycle, and that cycle begins on the second rising edge after acceptance. `ea_o` holds the result from that cycle onward.
- R3: The displacement is taken from the low bits of `disp_i` selected by `disp_sz_i` (0 = 8 bits, 1 = 16 bits, 2 = 32 bits). It is sign-extended to 32 bits and then added to the base value in mode 3 (base plus displacement). The unused upper bits of `disp_i` have no effect.
- R4: A base or index number of 15 reads `pc_i` as sampled at acceptance. Register 15 is never written.
- R5: Mode 1 (post-increment) uses the base value as the location. It then writes base + step to the base register. The step is 4 when `defer_i` = 1. Otherwise it is the operand size in bytes, 1 << `size_i` (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes).
- R6: Mode 2 (pre-decrement) uses base - step as the location and writes that same value to the base register. Mode 0 (register indirect) uses the base value as the location with no write.
- R7: With `defer_i` = 1, exactly one memory read is issued, with `mem_addr_o` equal to the location. `done_o` rises on the cycle after `mem_valid_i` is sampled, and the returned word then serves as the location.
- R8: With `idx_en_i` = 1, the index register value shifted left by `size_i` is added to the location. When `defer_i` = 1, this addition is applied to the fetched pointer. The index value is read before any base write of the same request.
- R9: After reset `req_ready_o` is high, and `done_o`, `mem_req_o` and `rf_we_o` are low.
- R10: Each request produces at most one single-cycle base write, and only in modes 1 and 2. `mem_req_o` is a single-cycle pulse with at most one read outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Specifier valid |
| req_ready_o | output | 1 | Block can take a specifier |
| mode_i | input | 2 | 0 indirect, 1 post-increment, 2 pre-decrement, 3 base plus displacement |
| base_i | input | 4 | Base register number |
| idx_en_i | input | 1 | Index register in use |
| idx_i | input | 4 | Index register number |
| disp_i | input | 32 | Raw displacement |
| disp_sz_i | input | 2 | Displacement width code |
| size_i | input | 2 | Operand size, log2 of bytes |
| defer_i | input | 1 | Location holds a pointer |
| pc_i | input | 32 | Program counter past the specifier |
| rf_raddr_base_o | output | 4 | Base register read address |
| rf_rdata_base_i | input | 32 | Base register read data |
| rf_raddr_idx_o | output | 4 | Index register read address |
| rf_rdata_idx_i | input | 32 | Index register read data |
| rf_we_o | output | 1 | Base register write enable |
| rf_waddr_o | output | 4 | Write register number |
| rf_wdata_o | output | 32 | Write data |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_valid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | 32 | Pointer read data |
| done_o | output | 1 | Address ready strobe |
| ea_o | output | 32 | Effective address |

## Verification
Two things can happen in the same cycle: the base register write and the index register read. When one register serves as both base and index in a post-increment or pre-decrement mode, the write and the read land together. The bench makes this happen in directed cases and often in random ones by drawing base and index from the full register range. It judges the result by requiring that the scaled index is the value from before the update, while the register file still receives the stepped base.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    AM_REGIND  = 2'd0,
    AM_AUTOINC = 2'd1,
    AM_AUTODEC = 2'd2,
    AM_DISP    = 2'd3
  } am_e;

  typedef enum logic [1:0] {
    DW_BYTE = 2'd0,
    DW_WORD = 2'd1,
    DW_LONG = 2'd2
  } dw_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_WAIT = 2'd2
  } ea_st_e;
endpackage

// File: rtl/ea_disp_sext.sv
module ea_disp_sext import ea_pkg::*; #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] raw_i,
  input  logic [1:0]    sz_i,
  output logic [AW-1:0] ext_o
);
  always_comb begin
    unique case (dw_e'(sz_i))
      DW_BYTE: ext_o = {{(AW-8){raw_i[7]}}, raw_i[7:0]};
      DW_WORD: ext_o = {{(AW-16){raw_i[15]}}, raw_i[15:0]};
      default: ext_o = raw_i;
    endcase
  end
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSIZE = 4
) (
  input  logic                     en_i,
  input  logic [AW-1:0]            idx_val_i,
  input  logic [$clog2(NSIZE)-1:0] size_i,
  output logic [AW-1:0]            scaled_o
);
  logic [AW-1:0] shifted [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_shift
    assign shifted[g] = idx_val_i << g;
  end

  assign scaled_o = en_i ? shifted[size_i] : '0;
endmodule

// File: rtl/ea_loc_calc.sv
module ea_loc_calc import ea_pkg::*; #(
  parameter int unsigned AW = 32
) (
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_val_i,
  input  logic [AW-1:0] disp_ext_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] loc_o,
  output logic [AW-1:0] new_base_o,
  output logic          wb_o
);
  always_comb begin
    loc_o      = base_val_i;
    new_base_o = base_val_i;
    wb_o       = 1'b0;
    unique case (am_e'(mode_i))
      AM_AUTOINC: begin
        new_base_o = base_val_i + step_i;
        wb_o       = 1'b1;
      end
      AM_AUTODEC: begin
        loc_o      = base_val_i - step_i;
        new_base_o = base_val_i - step_i;
        wb_o       = 1'b1;
      end
      AM_DISP: loc_o = base_val_i + disp_ext_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen import ea_pkg::*; #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    mode_i,
  input  logic [RW-1:0] base_i,
  input  logic          idx_en_i,
  input  logic [RW-1:0] idx_i,
  input  logic [AW-1:0] disp_i,
  input  logic [1:0]    disp_sz_i,
  input  logic [1:0]    size_i,
  input  logic          defer_i,
  input  logic [AW-1:0] pc_i,
  output logic [RW-1:0] rf_raddr_base_o,
  input  logic [AW-1:0] rf_rdata_base_i,
  output logic [RW-1:0] rf_raddr_idx_o,
  input  logic [AW-1:0] rf_rdata_idx_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [AW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o
);
  localparam logic [RW-1:0] PC_IDX   = RW'(NREG - 1);
  localparam int unsigned   PTR_STEP = AW / 8;

  ea_st_e        state_q;
  logic [1:0]    mode_q, disp_sz_q, size_q;
  logic [RW-1:0] base_q, idx_q;
  logic          idx_en_q, defer_q;
  logic [AW-1:0] disp_q, pc_q, scaled_q, ea_q, mem_addr_q;
  logic          done_q, mem_req_q;

  logic [AW-1:0] base_val, idx_val, disp_ext, step, loc, new_base, scaled;
  logic          wb_need;

  // register 15 is supplied by the decoder, never by the file
  assign base_val = (base_q == PC_IDX) ? pc_q : rf_rdata_base_i;
  assign idx_val  = (idx_q  == PC_IDX) ? pc_q : rf_rdata_idx_i;
  assign step     = defer_q ? AW'(PTR_STEP) : (AW'(1) << size_q);

  ea_disp_sext #(.AW(AW)) u_sext (
    .raw_i (disp_q),
    .sz_i  (disp_sz_q),
    .ext_o (disp_ext)
  );

  ea_loc_calc #(.AW(AW)) u_loc (
    .mode_i     (mode_q),
    .base_val_i (base_val),
    .disp_ext_i (disp_ext),
    .step_i     (step),
    .loc_o      (loc),
    .new_base_o (new_base),
    .wb_o       (wb_need)
  );

  ea_index_scale #(.AW(AW), .NSIZE(4)) u_scale (
    .en_i      (idx_en_q),
    .idx_val_i (idx_val),
    .size_i    (size_q),
    .scaled_o  (scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      disp_sz_q  <= '0;
      size_q     <= '0;
      base_q     <= '0;
      idx_q      <= '0;
      idx_en_q   <= 1'b0;
      defer_q    <= 1'b0;
      disp_q     <= '0;
      pc_q       <= '0;
      scaled_q   <= '0;
      ea_q       <= '0;
      mem_addr_q <= '0;
      done_q     <= 1'b0;
      mem_req_q  <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      mem_req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          mode_q    <= mode_i;
          disp_sz_q <= disp_sz_i;
          size_q    <= size_i;
          base_q    <= base_i;
          idx_q     <= idx_i;
          idx_en_q  <= idx_en_i;
          defer_q   <= defer_i;
          disp_q    <= disp_i;
          pc_q      <= pc_i;
          state_q   <= ST_CALC;
        end
        ST_CALC: begin
          scaled_q <= scaled;
          if (defer_q) begin
            mem_req_q  <= 1'b1;
            mem_addr_q <= loc;
            state_q    <= ST_WAIT;
          end else begin
            ea_q    <= loc + scaled;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: if (mem_valid_i) begin
          ea_q    <= mem_rdata_i + scaled_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign rf_raddr_base_o = base_q;
  assign rf_raddr_idx_o  = idx_q;
  assign rf_we_o         = (state_q == ST_CALC) && wb_need && (base_q != PC_IDX);
  assign rf_waddr_o      = base_q;
  assign rf_wdata_o      = new_base;
  assign mem_req_o       = mem_req_q;
  assign mem_addr_o      = mem_addr_q;
  assign done_o          = done_q;
  assign ea_o            = ea_q;
endmodule

// File: rtl/opnd_ea_gen_chk.sv
module opnd_ea_gen_chk #(
  parameter int unsigned RW   = 4,
  parameter int unsigned NREG = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          defer_i,
  input logic          rf_we_o,
  input logic [RW-1:0] rf_waddr_o,
  input logic          mem_req_o,
  input logic          mem_valid_i,
  input logic          done_o
);
  logic busy, waiting;
  logic accept;
  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      waiting <= 1'b0;
    end else begin
      if (accept)      busy <= 1'b1;
      else if (done_o) busy <= 1'b0;
      if (mem_req_o)        waiting <= 1'b1;
      else if (mem_valid_i) waiting <= 1'b0;
    end
  end

  assert_ready_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done_o |-> !req_ready_o);

  assert_done_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(accept && !defer_i, 2) |-> done_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_pc_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_waddr_o != RW'(NREG - 1));

  assert_ptr_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting && mem_valid_i |=> done_o);

  assert_we_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);

  assert_mem_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !waiting && busy);

  assert_mem_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
endmodule

bind opnd_ea_gen opnd_ea_gen_chk #(.RW(RW), .NREG(NREG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .defer_i     (defer_i),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .mem_req_o   (mem_req_o),
  .mem_valid_i (mem_valid_i),
  .done_o      (done_o)
);

// File: tb/opnd_ea_gen_tb_top.sv
`timescale 1ns/1ps
module opnd_ea_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  mode_i = '0;
  logic [3:0]  base_i = '0;
  logic        idx_en_i = 1'b0;
  logic [3:0]  idx_i = '0;
  logic [31:0] disp_i = '0;
  logic [1:0]  disp_sz_i = '0;
  logic [1:0]  size_i = '0;
  logic        defer_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [3:0]  rf_raddr_base_o, rf_raddr_idx_o, rf_waddr_o;
  logic [31:0] rf_rdata_base_i, rf_rdata_idx_i, rf_wdata_o;
  logic        rf_we_o, mem_req_o, done_o;
  logic [31:0] mem_addr_o, ea_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int wcnt = 0;
  int mcnt = 0;
  logic [31:0] maddr_seen = '0;

  logic [31:0] rf [16];
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  int          plat = 0;

  always #2 clk_i = ~clk_i;

  opnd_ea_gen dut_i (.*);

  assign rf_rdata_base_i = rf[rf_raddr_base_o];
  assign rf_rdata_idx_i  = rf[rf_raddr_idx_o];

  function automatic logic [31:0] mem_fn(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9bdf;
  endfunction

  always @(posedge clk_i) begin
    if (rf_we_o) begin
      rf[rf_waddr_o] <= rf_wdata_o;
      wcnt <= wcnt + 1;
    end
    if (mem_req_o) begin
      mcnt <= mcnt + 1;
      maddr_seen <= mem_addr_o;
    end
  end

  always @(negedge clk_i) begin
    mem_valid_i <= 1'b0;
    if (pend) begin
      if (plat == 0) begin
        mem_valid_i <= 1'b1;
        mem_rdata_i <= mem_fn(paddr);
        pend <= 1'b0;
      end else plat <= plat - 1;
    end
    if (mem_req_o) begin
      pend  <= 1'b1;
      paddr <= mem_addr_o;
      plat  <= int'($urandom % 3);
    end
  end

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] m, logic [3:0] b, logic xe, logic [3:0] x,
                        logic [31:0] d, logic [1:0] dsz, logic [1:0] sz,
                        logic df, logic [31:0] pc, string tag);
    logic [31:0] bv, xv, step, dext, loc, nb, ptr, ea_exp, b_before;
    int exp_w, w0, m0, lat;
    bool_blk: begin end
    bv   = (b == 4'd15) ? pc : rf[b];
    xv   = (x == 4'd15) ? pc : rf[x];
    step = df ? 32'd4 : (32'd1 << sz);
    case (dsz)
      2'd0:    dext = {{24{d[7]}}, d[7:0]};
      2'd1:    dext = {{16{d[15]}}, d[15:0]};
      default: dext = d;
    endcase
    loc = bv; nb = bv; exp_w = 0;
    case (m)
      2'd1: begin nb = bv + step; exp_w = 1; end
      2'd2: begin loc = bv - step; nb = loc; exp_w = 1; end
      2'd3: loc = bv + dext;
      default: ;
    endcase
    if (b == 4'd15) exp_w = 0;
    ptr    = df ? mem_fn(loc) : loc;
    ea_exp = ptr + (xe ? (xv << sz) : 32'd0);
    b_before = rf[b];
    w0 = wcnt; m0 = mcnt;

    @(negedge clk_i);
    mode_i = m; base_i = b; idx_en_i = xe; idx_i = x; disp_i = d;
    disp_sz_i = dsz; size_i = sz; defer_i = df; pc_i = pc;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    pc_i = $urandom;
    lat = 1;
    chk({"R1 ready low after accept ", tag}, {31'd0, req_ready_o}, 32'd0);
    while (!done_o) begin
      @(negedge clk_i);
      lat++;
    end
    chk({"R8 ea ", tag}, ea_o, ea_exp);
    if (!df) chk({"R2 latency ", tag}, lat, 32'd2);
    chk({"R10 write count ", tag}, wcnt - w0, exp_w);
    chk({"R7 mem read count ", tag}, mcnt - m0, {31'd0, df});
    if (df) chk({"R7 pointer address ", tag}, maddr_seen, loc);
    if (b != 4'd15) chk({"R5 R6 base after ", tag}, rf[b], exp_w ? nb : b_before);
    @(negedge clk_i);
    chk({"R2 done pulse ", tag}, {31'd0, done_o}, 32'd0);
    chk({"R2 ea held ", tag}, ea_o, ea_exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    repeat (3) @(negedge clk_i);
    chk("R9 ready at reset", {31'd0, req_ready_o}, 32'd1);
    chk("R9 done at reset", {31'd0, done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 ready after reset", {31'd0, req_ready_o}, 32'd1);
    chk("R9 mem_req after reset", {31'd0, mem_req_o}, 32'd0);
    chk("R9 we after reset", {31'd0, rf_we_o}, 32'd0);

    rf[3] = 32'h0000_1000;
    run_op(2'd3, 4'd3, 1'b0, 4'd0, 32'hABCD_EF80, 2'd0, 2'd2, 1'b0, 32'h0, "R3 byte neg");
    run_op(2'd3, 4'd3, 1'b0, 4'd0, 32'h1234_8000, 2'd1, 2'd2, 1'b0, 32'h0, "R3 word neg");
    run_op(2'd3, 4'd3, 1'b0, 4'd0, 32'h8000_0004, 2'd2, 2'd2, 1'b0, 32'h0, "R3 long");
    run_op(2'd3, 4'd15, 1'b0, 4'd0, 32'h0000_0010, 2'd0, 2'd2, 1'b0, 32'h4000, "R4 pc rel");
    run_op(2'd1, 4'd15, 1'b0, 4'd0, 32'h0, 2'd0, 2'd2, 1'b0, 32'h8000, "R4 pc inc no write");
    rf[5] = 32'h0000_2000;
    run_op(2'd1, 4'd5, 1'b0, 4'd0, 32'h0, 2'd0, 2'd2, 1'b0, 32'h0, "R5 autoinc long");
    run_op(2'd2, 4'd5, 1'b0, 4'd0, 32'h0, 2'd0, 2'd3, 1'b0, 32'h0, "R6 autodec quad");
    run_op(2'd0, 4'd5, 1'b0, 4'd0, 32'h0, 2'd0, 2'd0, 1'b0, 32'h0, "R6 indirect");
    run_op(2'd1, 4'd5, 1'b0, 4'd0, 32'h0, 2'd0, 2'd0, 1'b1, 32'h0, "R7 deferred inc step4");
    rf[6] = 32'h0000_0003;
    run_op(2'd1, 4'd6, 1'b1, 4'd6, 32'h0, 2'd0, 2'd2, 1'b0, 32'h0, "R8 base eq index");
    run_op(2'd2, 4'd6, 1'b1, 4'd6, 32'h0, 2'd0, 2'd1, 1'b0, 32'h0, "R8 dec base eq index");
    run_op(2'd3, 4'd3, 1'b1, 4'd5, 32'h0000_0020, 2'd0, 2'd3, 1'b1, 32'h0, "R8 deferred disp index");

    for (int k = 0; k < 300; k++) begin
      run_op(2'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom,
             2'($urandom % 3), 2'($urandom), 1'($urandom), $urandom, "random");
    end

    summary();
    $finish;
  end
endmodule